// File: doc/BRIEF.md
# PCI Delayed Read Target Controller

This block is the target side of a PCI bus placed in front of a memory that may be slow to answer. Every memory read whose address falls in the target window is claimed. The command and address go into a single delayed-transaction slot, and the slot starts a read on a request/response memory port in the next cycle. If data comes back quickly, the block completes the data phase with TRDY#. If the memory is slow and both control bits are set, the block gives up on the bus when the target latency window ends. It signals a retry: STOP# asserted, DEVSEL# asserted and TRDY# deasserted. The memory read keeps running in the background.

The slot holds at most one pending read. When the originating master repeats the identical request, the buffered word is returned and the slot becomes free. Any other read that targets this block while the slot is occupied is retried and is not queued. Reads that fall outside the window, and commands other than memory read, are never claimed. This lets peer-to-peer traffic pass while a delayed read is pending. If either control bit is clear, the block simply holds the bus until memory answers.

The memory side uses valid/ready. `mem_req_valid` stays high, and `mem_req_addr` stays stable, until `mem_req_ready` is sampled high. At most one request is in flight. `mem_rsp_ready` is high only while a response is awaited. A response word is taken on the edge where both `mem_rsp_valid` and `mem_rsp_ready` are high, and the memory must hold `mem_rsp_valid` and its data until then.

Top module: `pci_dly_rd_tgt`

## Requirements
- R1: In reset and right after it, `devsel_n`, `trdy_n` and `stop_n` are high, and `mem_req_valid` and `mem_rsp_ready` are low.
- R2: A transaction is claimed only when the command is memory read (4'b0110) and address bits [AW-1:AW-DEC_BITS] equal TGT_BASE. In every other case `devsel_n` stays high, and no memory request is issued.
- R3: A fresh claimed read with the slot empty raises `mem_req_valid` with the captured address after the address edge. Under back-pressure, valid and address are held until `mem_req_ready` is high.
- R4: If the slot holds data when checked, `trdy_n` goes low for exactly one cycle with `rd_data` equal to the memory word and `stop_n` high. For a fresh read with memory delay D, this happens 4+D edges after the address edge (bench memory model). It never happens later than edge 31.
- R5: With both enables set, if no data is ready by the 31st edge after the address edge, `stop_n` goes low from that edge with `devsel_n` low and `trdy_n` high. It stays low until `frame_n` and `irdy_n` are both high, and releases on the following edge.
- R6: With either enable clear, no timeout occurs. The bus is held with `trdy_n` high until data arrives, even well past 31 edges.
- R7: While the slot is occupied, a claimed read with a different command or address is retried on the edge after the address edge, and no memory request is issued.
- R8: A matching repeat whose data has not yet returned is retried immediately (both enables set), and the slot is kept.
- R9: A matching repeat with data present gets `trdy_n` one edge after the address edge with the buffered word. The slot is then freed, so the next new read issues a fresh request.
- R10: Unclaimed traffic during a pending delayed read leaves that read running, and its data is later delivered.
- R11: At most one memory request is outstanding. `mem_rsp_ready` is never high while `mem_req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cfg_dly_en | input | 1 | Delayed-transaction enable |
| cfg_lat_en | input | 1 | Target latency enforcement enable |
| frame_n | input | 1 | Master transaction framing, low while active |
| irdy_n | input | 1 | Master ready, low while active |
| bus_cmd | input | 4 | Command sampled on the address edge |
| bus_addr | input | AW | Address sampled on the address edge |
| devsel_n | output | 1 | Target claims the transaction |
| trdy_n | output | 1 | Target data ready |
| stop_n | output | 1 | Target retry request |
| rd_data | output | DW | Read word, valid while `trdy_n` is low |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Block accepts response |
| mem_rsp_data | input | DW | Memory response word |

## Verification
The properties assume a well-behaved master. It drives `frame_n` and `irdy_n` low together for one address edge, keeps them low until it sees TRDY# or STOP#, then releases both and leaves at least one idle edge. They also assume that the memory holds a response until it is accepted and that the control bits change only while the bus is idle. The stimulus follows these rules. Each transaction and each change of the enable bits is set up on a falling edge while the bus is idle, and the bus is released right after a termination is observed. The bench memory is a model that answers after a programmable delay and can stall its ready line.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_RETRY,
    ST_DRAIN
  } pdr_state_e;
endpackage

// File: rtl/pdr_decode.sv
module pdr_decode #(
  parameter int AW = 32,
  parameter int DEC_BITS = 4,
  parameter logic [DEC_BITS-1:0] TGT_BASE = '0
) (
  input  logic [3:0]    cmd,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    slot_cmd,
  input  logic [AW-1:0] slot_addr,
  output logic          hit,
  output logic          match
);
  import pdr_pkg::*;

  logic in_window;
  assign in_window = (addr[AW-1 -: DEC_BITS] == TGT_BASE);
  assign hit       = in_window && (cmd == CMD_MEM_RD);
  // full compare of command and address against the stored request
  assign match     = (cmd == slot_cmd) && (addr == slot_addr);
endmodule

// File: rtl/pdr_lat_cnt.sv
module pdr_lat_cnt #(
  parameter int LAT_CLKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LAT_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(LAT_CLKS - 1);
  localparam logic [CW-1:0] TOP  = CW'(LAT_CLKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(1);
    end else if (run && cnt_q != TOP) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/pdr_slot.sv
module pdr_slot #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [3:0]    alloc_cmd,
  input  logic [AW-1:0] alloc_addr,
  input  logic          free,
  output logic          busy,
  output logic          ready,
  output logic [3:0]    s_cmd,
  output logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data
);
  logic busy_q, ready_q, req_q, await_q;
  logic [3:0]    cmd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic req_fire, rsp_fire;
  assign req_fire = req_q && mem_req_ready;
  assign rsp_fire = await_q && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      req_q   <= 1'b0;
      await_q <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (alloc && !busy_q) begin
        busy_q  <= 1'b1;
        ready_q <= 1'b0;
        req_q   <= 1'b1;
        cmd_q   <= alloc_cmd;
        addr_q  <= alloc_addr;
      end else if (free) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b0;
      end else begin
        if (req_fire) begin
          req_q   <= 1'b0;
          await_q <= 1'b1;
        end
        if (rsp_fire) begin
          await_q <= 1'b0;
          ready_q <= 1'b1;
          data_q  <= mem_rsp_data;
        end
      end
    end
  end

  assign busy          = busy_q;
  assign ready         = ready_q;
  assign s_cmd         = cmd_q;
  assign s_addr        = addr_q;
  assign s_data        = data_q;
  assign mem_req_valid = req_q;
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = await_q;
endmodule

// File: rtl/pci_dly_rd_tgt.sv
module pci_dly_rd_tgt #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEC_BITS = 4,
  parameter logic [DEC_BITS-1:0] TGT_BASE = 4'h4,
  parameter int LAT_CLKS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dly_en,
  input  logic          cfg_lat_en,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [3:0]    bus_cmd,
  input  logic [AW-1:0] bus_addr,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          stop_n,
  output logic [DW-1:0] rd_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [DW-1:0] mem_rsp_data
);
  import pdr_pkg::*;

  pdr_state_e state_q, state_d;
  logic hit, match, busy, ready, expired;
  logic alloc, free, tmo_en, start, in_wait;
  logic [3:0]    s_cmd;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic [DW-1:0] rd_q;

  assign tmo_en  = cfg_dly_en && cfg_lat_en;
  assign start   = (state_q == ST_IDLE) && !frame_n;
  assign in_wait = (state_q == ST_WAIT);

  pdr_decode #(.AW(AW), .DEC_BITS(DEC_BITS), .TGT_BASE(TGT_BASE)) u_dec (
    .cmd       (bus_cmd),
    .addr      (bus_addr),
    .slot_cmd  (s_cmd),
    .slot_addr (s_addr),
    .hit       (hit),
    .match     (match)
  );

  pdr_lat_cnt #(.LAT_CLKS(LAT_CLKS)) u_lat (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .run     (in_wait),
    .expired (expired)
  );

  pdr_slot #(.AW(AW), .DW(DW)) u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc         (alloc),
    .alloc_cmd     (bus_cmd),
    .alloc_addr    (bus_addr),
    .free          (free),
    .busy          (busy),
    .ready         (ready),
    .s_cmd         (s_cmd),
    .s_addr        (s_addr),
    .s_data        (s_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data)
  );

  always_comb begin
    state_d = state_q;
    alloc   = 1'b0;
    free    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!frame_n) begin
          if (!hit) begin
            state_d = ST_DRAIN;
          end else if (!busy) begin
            alloc   = 1'b1;
            state_d = ST_WAIT;
          end else if (!match) begin
            state_d = ST_RETRY;          // one slot only: no queueing
          end else if (!ready && tmo_en) begin
            state_d = ST_RETRY;          // repeat arrived before the data
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (ready) begin
          free    = 1'b1;
          state_d = ST_DATA;
        end else if (tmo_en && expired) begin
          state_d = ST_RETRY;
        end
      end
      ST_DATA: state_d = ST_DRAIN;
      ST_RETRY, ST_DRAIN: begin
        if (frame_n && irdy_n) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (free) rd_q <= s_data;
    end
  end

  assign devsel_n = !((state_q == ST_WAIT) || (state_q == ST_DATA) || (state_q == ST_RETRY));
  assign trdy_n   = (state_q != ST_DATA);
  assign stop_n   = (state_q != ST_RETRY);
  assign rd_data  = rd_q;
endmodule

// File: rtl/pdr_chk.sv
module pdr_chk #(
  parameter int AW = 32,
  parameter int LAT_CLKS = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_dly_en,
  input logic          cfg_lat_en,
  input logic          frame_n,
  input logic          devsel_n,
  input logic          trdy_n,
  input logic          stop_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_ready,
  input logic          st_wait
);
  logic [15:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (!devsel_n && trdy_n && stop_n) begin
      if (hold_cnt != 16'hFFFF) hold_cnt <= hold_cnt + 16'd1;
    end else begin
      hold_cnt <= '0;
    end
  end

  a_r5_retry_shape: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> (!devsel_n && trdy_n));

  a_r5_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dly_en && cfg_lat_en) |-> (hold_cnt < 16'(LAT_CLKS)));

  a_r4_trdy_single: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |=> trdy_n);

  a_r2_claim_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  a_r6_timeout_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && $past(st_wait)) |-> $past(cfg_dly_en && cfg_lat_en));
endmodule

bind pci_dly_rd_tgt pdr_chk #(.AW(AW), .LAT_CLKS(LAT_CLKS)) u_pdr_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_dly_en    (cfg_dly_en),
  .cfg_lat_en    (cfg_lat_en),
  .frame_n       (frame_n),
  .devsel_n      (devsel_n),
  .trdy_n        (trdy_n),
  .stop_n        (stop_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .st_wait       (in_wait)
);

// File: tb/test_pci_dly_rd_tgt.sv
`timescale 1ns/1ps
module test_pci_dly_rd_tgt;
  localparam logic [1:0] K_DATA = 2'd0, K_RETRY = 2'd1, K_NONE = 2'd2, K_HUNG = 2'd3;
  localparam logic [3:0] RD = 4'b0110, WR = 4'b0111;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [1:0]  en;     // {dly, lat}
    logic [7:0]  mdly;
    logic [7:0]  gap;
    logic [1:0]  kind;
    logic [8:0]  k;
    logic [1:0]  rq;     // memory requests expected in this row
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h4000_0100, RD, 2'b11, 8'd5,  8'd0,  K_DATA,  9'd9,  2'd1, 4'd4},  // R4 fast
    '{32'h4000_0100, RD, 2'b11, 8'd27, 8'd0,  K_DATA,  9'd31, 2'd1, 4'd4},  // R4 last edge
    '{32'h4000_0200, RD, 2'b11, 8'd28, 8'd0,  K_RETRY, 9'd31, 2'd1, 4'd5},  // R5 timeout
    '{32'h4000_0300, RD, 2'b11, 8'd3,  8'd0,  K_RETRY, 9'd0,  2'd0, 4'd7},  // R7 other addr
    '{32'h4000_0200, RD, 2'b11, 8'd3,  8'd0,  K_DATA,  9'd1,  2'd0, 4'd9},  // R9 repeat
    '{32'h4000_0300, RD, 2'b11, 8'd3,  8'd0,  K_DATA,  9'd7,  2'd1, 4'd9},  // R9 slot freed
    '{32'h4000_0400, RD, 2'b11, 8'd60, 8'd0,  K_RETRY, 9'd31, 2'd1, 4'd5},  // R5
    '{32'h4000_0400, RD, 2'b11, 8'd3,  8'd0,  K_RETRY, 9'd0,  2'd0, 4'd8},  // R8 early repeat
    '{32'h2000_0400, RD, 2'b11, 8'd3,  8'd0,  K_NONE,  9'd0,  2'd0, 4'd10}, // R10 peer
    '{32'h4000_0400, WR, 2'b11, 8'd3,  8'd0,  K_NONE,  9'd0,  2'd0, 4'd2},  // R2 write
    '{32'h4000_0400, RD, 2'b11, 8'd3,  8'd40, K_DATA,  9'd1,  2'd0, 4'd10}, // R10 delivered
    '{32'h4000_0500, RD, 2'b01, 8'd40, 8'd0,  K_DATA,  9'd44, 2'd1, 4'd6},  // R6 dly off
    '{32'h4000_0600, RD, 2'b10, 8'd35, 8'd0,  K_DATA,  9'd39, 2'd1, 4'd6},  // R6 lat off
    '{32'h4000_0700, RD, 2'b00, 8'd28, 8'd0,  K_DATA,  9'd32, 2'd1, 4'd6}   // R6 both off
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dly_en = 1'b0, cfg_lat_en = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0] bus_cmd = '0;
  logic [31:0] bus_addr = '0;
  logic devsel_n, trdy_n, stop_n, mem_req_valid, mem_req_ready, mem_rsp_ready;
  logic [31:0] rd_data, mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0, fails = 0, req_cnt = 0;
  int mem_dly = 0, m_cnt = 0;
  logic m_busy = 1'b0, stall = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  pci_dly_rd_tgt i_pci_dly_rd_tgt (
    .clk, .rst_n, .cfg_dly_en, .cfg_lat_en, .frame_n, .irdy_n, .bus_cmd, .bus_addr,
    .devsel_n, .trdy_n, .stop_n, .rd_data, .mem_req_valid, .mem_req_ready,
    .mem_req_addr, .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_A5A5;
  endfunction

  assign mem_req_ready = !m_busy && !stall;

  // memory model: answers mem_dly+1 edges after accepting a request
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) req_cnt <= req_cnt + 1;
    if (mem_rsp_valid) begin
      if (mem_rsp_ready) begin
        mem_rsp_valid <= 1'b0;
        m_busy <= 1'b0;
      end
    end else if (m_busy) begin
      if (m_cnt == 0) mem_rsp_valid <= 1'b1;
      else m_cnt <= m_cnt - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      m_busy <= 1'b1;
      m_cnt <= mem_dly;
      mem_rsp_data <= mem_word(mem_req_addr);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_bus();
    frame_n = 1'b1; irdy_n = 1'b1; bus_cmd = '0; bus_addr = '0;
  endtask

  task automatic run_row(input vec_t v);
    logic [1:0] got;
    logic [31:0] dat;
    int k, r0;
    string tag;
    tag = $sformatf("R%0d", v.req);
    repeat (v.gap) @(posedge clk);
    @(negedge clk);
    cfg_dly_en = v.en[1]; cfg_lat_en = v.en[0]; mem_dly = int'(v.mdly);
    r0 = req_cnt;
    frame_n = 1'b0; irdy_n = 1'b0; bus_cmd = v.cmd; bus_addr = v.addr;
    got = K_HUNG; k = 0; dat = '0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (!trdy_n) begin got = K_DATA; dat = rd_data; k = i; break; end
      if (!stop_n) begin got = K_RETRY; k = i; break; end
      if (i == 3 && devsel_n) begin got = K_NONE; break; end
    end
    check(got == v.kind, {tag, " kind"}, 32'(got), 32'(v.kind));
    if (v.kind != K_NONE)
      check(k == int'(v.k), {tag, " edge"}, k, 32'(v.k));
    if (got == K_DATA) begin
      check(dat == mem_word(v.addr) && stop_n, {tag, " data"}, dat, mem_word(v.addr));
      release_bus();
      @(posedge clk); #1;
      check(trdy_n, "R4 trdy one cycle", 32'(trdy_n), 32'd1);
    end else if (got == K_RETRY) begin
      for (int j = 0; j < 3; j++) begin
        @(posedge clk); #1;
        check(!stop_n && !devsel_n && trdy_n, "R5 retry held", {29'd0, stop_n, devsel_n, trdy_n}, 32'd1);
      end
      release_bus();
      @(posedge clk); #1;
      check(stop_n && devsel_n, "R5 retry released", {30'd0, stop_n, devsel_n}, 32'd3);
    end else begin
      release_bus();
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    check(req_cnt - r0 == int'(v.rq), {tag, " requests"}, req_cnt - r0, 32'(v.rq));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(posedge clk); #1;
    // R1: outputs idle during reset
    check(devsel_n && trdy_n && stop_n, "R1 bus idle", {29'd0, devsel_n, trdy_n, stop_n}, 32'd7);
    check(!mem_req_valid && !mem_rsp_ready, "R1 mem idle", {30'd0, mem_req_valid, mem_rsp_ready}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(devsel_n && trdy_n && stop_n && !mem_req_valid, "R1 after reset",
          {28'd0, devsel_n, trdy_n, stop_n, mem_req_valid}, 32'd14);

    for (int n = 0; n < NV; n++) run_row(VEC[n]);

    // R3 / R11: back-pressured request stays put, response path closed
    repeat (2) @(posedge clk);
    @(negedge clk);
    stall = 1'b1; cfg_dly_en = 1'b1; cfg_lat_en = 1'b1; mem_dly = 2;
    frame_n = 1'b0; irdy_n = 1'b0; bus_cmd = RD; bus_addr = 32'h4000_0800;
    k = 0;
    for (int i = 0; i < 6; i++) begin @(posedge clk); #1; end
    check(mem_req_valid && mem_req_addr == 32'h4000_0800, "R3 request held", mem_req_addr, 32'h4000_0800);
    check(!mem_rsp_ready, "R11 no rsp_ready while request pending", 32'(mem_rsp_ready), 32'd0);
    stall = 1'b0;
    for (int i = 6; i < 100; i++) begin
      @(posedge clk); #1;
      if (!trdy_n || !stop_n) begin k = i; break; end
    end
    check(!trdy_n && rd_data == mem_word(32'h4000_0800), "R3 data after stall", rd_data, mem_word(32'h4000_0800));
    check(k == 11, "R3 edge after stall", k, 32'd11);
    release_bus();
    repeat (3) @(posedge clk); #1;
    check(!mem_rsp_ready && !mem_req_valid, "R11 idle memory port", {30'd0, mem_req_valid, mem_rsp_ready}, 32'd0);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule